// File: doc/BRIEF.md
# Gated Programmable Interval Timer

A 16-bit up-counter for use as a general-purpose interval timer. Its increment source is a prescaled bus-clock enable, taken undivided, divided by 16 or divided by 256. It can also take one increment per rising edge of the horizontal-blank input. A compare register defines a match point. The counter can return to zero at that point, and it always wraps to zero after the all-ones value. Both the match event and the wrap event can latch a sticky flag, and the interrupt output is a level derived from those flags.

Counting can be qualified by one of two video timing inputs, horizontal or vertical blank. In the level mode, counting is held off while the selected input is high. In the edge modes, the counter is cleared and started on a rising edge, a falling edge, or either edge. Software controls the block through a small write/read port with three registers: count, control and compare. It clears the flags by writing ones to them.

Top module: `gated_interval_timer`

## Requirements
- R1: After reset, count reads 0x0000, control reads 0x000, compare reads 0xFFFF and irq is low.
- R2: Register selection by addr: 0 selects count, 1 selects control (bits [9:0] settings, bit 10 match flag, bit 11 overflow flag), 2 selects compare. A count write loads the value and clears the prescaler.
- R3: Control bits [1:0] select the increment source. 0 is every cycle with clk_en high. 1 is every 16th such cycle and 2 is every 256th, both measured from the last count write or counter clear. 3 is each rising edge of hblank.
- R4: Control bit 7 enables counting. While it is clear, the count holds its value.
- R5: Control bit 2 enables gating, and bit 3 picks the gate input (0 = hblank, 1 = vblank). With gate behaviour [5:4] = 0, no increment happens while the selected input is high.
- R6: With gate behaviour 1, 2 or 3, a rising edge, a falling edge, or either edge (respectively) of the selected input clears the count, both flags and the prescaler, and sets control bit 7.
- R7: When control bits [3:0] equal 0111, gating has no effect.
- R8: With bit 8 set, an increment that lands on the compare value sets the match flag (bit 10). The flag stays set, and irq stays high, until the flag is cleared.
- R9: With bit 6 set, an increment that lands on the compare value yields 0 instead of the compare value.
- R10: An increment from 0xFFFF yields 0. If bit 9 is set, it also sets the overflow flag (bit 11) and irq goes high.
- R11: A control write loads bits [9:0]. Writing 1 to bit 10 or bit 11 clears that flag, and writing 0 leaves it unchanged.
- R12: A flag is not set when its enable (bit 8 or bit 9) is clear, and irq stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Bus clock enable, input to the prescaler |
| hblank | input | 1 | Horizontal blank level |
| vblank | input | 1 | Vertical blank level |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following every cycle:
- the count is held while stopped;
- a wrap from all-ones goes to zero and, when enabled, latches the overflow flag;
- the match flag is sticky;
- a gate edge leaves a cleared, running counter with irq low;
- the forced-off gating pattern never suppresses an hblank increment;
- irq rises only after an increment or a control write.

Only the bench scenarios can show the exact divide periods counted from a write, the full set of gate-behaviour and source combinations, the choice of landing value when a match coincides with reset-on-compare, and the write-one-to-clear semantics against mode bits that are preserved.

// File: rtl/gated_interval_timer.sv
module gated_interval_timer #(
  parameter int CW       = 16,
  parameter int MID_LOG2 = 4,
  parameter int SLO_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          hblank,
  input  logic          vblank,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int PW = SLO_LOG2;

  logic [CW-1:0] cnt_q, tgt_q;
  logic [9:0]    ctl_q;
  logic          match_f, ovf_f;
  logic [PW-1:0] pre_q;
  logic          hb_q, vb_q;
  logic          tick;

  wire run     = ctl_q[7];
  wire gate_on = ctl_q[2] && (ctl_q[3:0] != 4'b0111);
  wire g_now   = ctl_q[3] ? vblank : hblank;
  wire g_prev  = ctl_q[3] ? vb_q : hb_q;
  wire g_rise  = g_now & ~g_prev;
  wire g_fall  = ~g_now & g_prev;
  wire [1:0] gmode = ctl_q[5:4];

  wire gate_rst = gate_on && ((gmode == 2'd1 && g_rise) ||
                              (gmode == 2'd2 && g_fall) ||
                              (gmode == 2'd3 && (g_rise || g_fall)));
  wire inhibit  = gate_on && (gmode == 2'd0) && g_now;

  always_comb begin
    case (ctl_q[1:0])
      2'd0:    tick = clk_en;
      2'd1:    tick = clk_en && (&pre_q[MID_LOG2-1:0]);
      2'd2:    tick = clk_en && (&pre_q);
      default: tick = hblank & ~hb_q;
    endcase
  end

  wire          step   = run && tick && !inhibit;
  wire [CW-1:0] nxt    = cnt_q + 1'b1;
  wire          wrap   = &cnt_q;
  wire          hit    = (nxt == tgt_q);
  wire          wr_cnt = wr_en && (addr == 2'd0);
  wire          wr_ctl = wr_en && (addr == 2'd1);
  wire          wr_tgt = wr_en && (addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tgt_q   <= '1;
      ctl_q   <= '0;
      match_f <= 1'b0;
      ovf_f   <= 1'b0;
      pre_q   <= '0;
      hb_q    <= 1'b0;
      vb_q    <= 1'b0;
    end else begin
      hb_q <= hblank;
      vb_q <= vblank;
      if (clk_en) pre_q <= pre_q + 1'b1;
      if (wr_cnt) begin
        cnt_q <= wdata;
        pre_q <= '0;
      end else if (gate_rst) begin
        cnt_q    <= '0;
        pre_q    <= '0;
        match_f  <= 1'b0;
        ovf_f    <= 1'b0;
        ctl_q[7] <= 1'b1;
      end else if (step) begin
        cnt_q <= (hit && ctl_q[6]) ? '0 : nxt;
        if (hit && ctl_q[8]) match_f <= 1'b1;
        if (wrap && ctl_q[9]) ovf_f <= 1'b1;
      end
      if (wr_ctl) begin
        ctl_q <= wdata[9:0];
        if (wdata[10]) match_f <= 1'b0;
        if (wdata[11]) ovf_f <= 1'b0;
      end
      if (wr_tgt) tgt_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt_q;
      2'd1:    rdata = {{(CW-12){1'b0}}, ovf_f, match_f, ctl_q};
      2'd2:    rdata = tgt_q;
      default: rdata = '0;
    endcase
  end

  assign irq = (match_f & ctl_q[8]) | (ovf_f & ctl_q[9]);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !gate_rst) |=> $stable(cnt_q));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap && !wr_cnt && !gate_rst) |=> (cnt_q == '0));

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap && ctl_q[9] && !wr_cnt && !gate_rst && !(wr_ctl && wdata[11])) |=> ovf_f);

  // R8
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_f && !gate_rst && !(wr_ctl && wdata[10])) |=> match_f);

  // R6
  gate_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rst && !wr_cnt && !wr_ctl) |=> (cnt_q == '0 && ctl_q[7] && !irq));

  // R7
  forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == {ctl_q[9:8], 1'b1, 1'b0, ctl_q[5:4], 4'b0111} && hblank && !hb_q && !wr_cnt)
    |=> (cnt_q != $past(cnt_q)));

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(step) || $past(wr_ctl)));
endmodule

// File: tb/gated_interval_timer_tb.sv
module gated_interval_timer_tb;
  logic clk = 0, rst_n = 0, clk_en = 0, hblank = 0, vblank = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic irq;

  always #5 clk = ~clk;

  gated_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .hblank(hblank), .vblank(vblank),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int pending = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  initial begin
    forever begin
      item_t it;
      logic [15:0] act;
      wait (pending != 0);
      #1;
      it = q.pop_front();
      pending--;
      act = (it.sel == 4) ? {15'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic chk(input int sel, input logic [15:0] exp, input string req);
    item_t it;
    if (sel < 4) addr = sel[1:0];
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    pending++;
    #2;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic en(input int n);
    clk_en = 1;
    repeat (n) @(negedge clk);
    clk_en = 0;
  endtask

  task automatic hpulse();
    hblank = 1; @(negedge clk);
    hblank = 0; @(negedge clk);
  endtask

  task automatic gedge(input logic v);
    vblank = v; @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(0, 16'h0000, "R1"); chk(1, 16'h0000, "R1"); chk(2, 16'hFFFF, "R1"); chk(4, 0, "R1");

    // R3 R4 undivided, then stop
    wr(1, 16'h080); en(5); chk(0, 5, "R3");
    wr(1, 16'h000); en(3); chk(0, 5, "R4"); chk(1, 16'h000, "R4");

    // R2
    wr(0, 16'h1234); chk(0, 16'h1234, "R2");
    wr(2, 16'h0042); chk(2, 16'h0042, "R2");

    // R3 divide by 16 and 256
    wr(1, 16'h081); wr(0, 0); en(15); chk(0, 0, "R3"); en(1); chk(0, 1, "R3");
    wr(1, 16'h082); wr(0, 0); en(255); chk(0, 0, "R3"); en(1); chk(0, 1, "R3");
    en(256); chk(0, 2, "R3");

    // R3 hblank source
    wr(1, 16'h083); wr(0, 0); hpulse(); hpulse(); hpulse(); chk(0, 3, "R3");
    hblank = 1; repeat (4) @(negedge clk); hblank = 0; @(negedge clk); chk(0, 4, "R3");

    // R8 R11 match and write-one-to-clear
    wr(2, 10); wr(1, 16'h180); wr(0, 0);
    en(9); chk(0, 9, "R8"); chk(4, 0, "R8");
    en(1); chk(0, 10, "R8"); chk(1, 16'h580, "R8"); chk(4, 1, "R8");
    en(5); chk(0, 15, "R8"); chk(4, 1, "R8");
    wr(1, 16'h180); chk(1, 16'h580, "R11");
    wr(1, 16'h580); chk(1, 16'h180, "R11"); chk(4, 0, "R11");

    // R9 R12 reset on compare without compare interrupt
    wr(2, 4); wr(1, 16'h0C0); wr(0, 0);
    en(3); chk(0, 3, "R9"); en(1); chk(0, 0, "R9"); en(2); chk(0, 2, "R9");
    chk(1, 16'h0C0, "R12"); chk(4, 0, "R12");

    // R10 overflow
    wr(2, 5); wr(1, 16'h280); wr(0, 16'hFFFE);
    en(1); chk(0, 16'hFFFF, "R10"); chk(4, 0, "R10");
    en(1); chk(0, 0, "R10"); chk(1, 16'hA80, "R10"); chk(4, 1, "R10");
    wr(1, 16'hA80); chk(1, 16'h280, "R11"); chk(4, 0, "R11");
    wr(1, 16'h080); wr(0, 16'hFFFF); en(1);
    chk(0, 0, "R10"); chk(1, 16'h080, "R12"); chk(4, 0, "R12");

    // R5 level gating
    wr(0, 0); wr(1, 16'h08C); gedge(1);
    en(4); chk(0, 0, "R5");
    vblank = 0; en(4); chk(0, 4, "R5");
    hblank = 1; en(2); chk(0, 6, "R5");
    wr(1, 16'h084); en(3); chk(0, 6, "R5");
    hblank = 0; @(negedge clk);

    // R7 forced-off pattern
    wr(1, 16'h087); wr(0, 0); hpulse(); hpulse(); chk(0, 2, "R7");

    // R6 edge modes
    wr(1, 16'h01C); wr(0, 16'h0050); chk(0, 16'h0050, "R4");
    gedge(1); chk(0, 0, "R6"); chk(1, 16'h09C, "R6");
    en(3); chk(0, 3, "R6");
    gedge(0); chk(0, 3, "R6");
    wr(1, 16'h0AC); wr(0, 7); gedge(1); chk(0, 7, "R6");
    gedge(0); chk(0, 0, "R6");
    wr(1, 16'h0BC); wr(0, 9); gedge(1); chk(0, 0, "R6");
    en(2); chk(0, 2, "R6");
    gedge(0); chk(0, 0, "R6");
    wr(2, 2); wr(1, 16'h1BC); wr(0, 0); en(2);
    chk(1, 16'h5BC, "R6"); chk(4, 1, "R6");
    gedge(1); chk(0, 0, "R6"); chk(1, 16'h1BC, "R6"); chk(4, 0, "R6");
    gedge(0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule